// File: doc/BRIEF.md
# Run-Time Resizable Instruction Cache

This block is a set-associative instruction cache whose usable region can be narrowed while the system runs. Two configuration registers set the region. One register enables a subset of the ways. The other register is a set mask that is ANDed onto the index, so only a smaller range of sets is used. A scheduler can give each task just the capacity it needs, either alone or overlapping with other tasks. Tags hold the whole line address, so lines from different tasks or from different mask settings never alias when they share storage.

Each line has an awake flag. A line outside the active region is drowsy and drops back to that state as soon as the region shrinks. A lookup that finds any enabled way of its set drowsy spends one extra cycle waking those lines. On a miss the cache asks the memory side for the whole line. The new line goes only into an enabled way: an empty enabled way first, and otherwise the next enabled way after a per-set rotating pointer. A change of configuration never flushes lines. A line that falls outside the region becomes unreachable, and it hits again once the region covers it. The hit and miss outputs each pulse for one cycle, so a miss-rate monitor can count them.

Top module: `rcfg_icache`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1 and `resp_valid`, `hit_evt`, `miss_evt` and `refill_req_valid` are 0. All lines are invalid and drowsy, all ways are enabled and the set mask is all ones.
- R2: A lookup that hits an awake line raises `resp_valid` together with a one-cycle `hit_evt` on the cycle after the request is accepted. `resp_data` is the addressed 32-bit word.
- R3: A lookup that misses pulses `miss_evt` and raises `refill_req_valid` at the same time. `refill_addr` is the request address with its low 4 bits cleared, and both stay held until `refill_valid` is sampled. On the cycle after that, `resp_valid` rises with the requested word.
- R4: The set index is `req_addr[11:4] & set_mask`, so two addresses that differ only in masked index bits compete for the same set.
- R5: Only the enabled ways can hit. A line held in a disabled way misses.
- R6: The line that a miss brings in goes to the lowest-numbered enabled way that is invalid. If none is invalid, it goes to the first enabled way found at or cyclically after the set's pointer. After every fill, the pointer becomes the filled way plus one, modulo the way count.
- R7: Writing 0 to the way-select register enables way 0 alone.
- R8: A configuration write keeps the valid lines. A line in a way that is disabled and later enabled again hits without a refill.
- R9: A lookup whose set has any enabled way drowsy takes one extra cycle before its hit or miss, and it wakes all enabled ways of that set. Lines leave the awake state when their way is disabled or their set leaves the mask.
- R10: Within a 16-byte line, bits 31:0 hold the word at offset 0 and each higher word sits 32 bits above the previous one. `req_addr[3:2]` selects the word, on a hit and on a refill response alike.
- R11: Configuration register select 0 is the way-select register, which takes `cfg_wdata[3:0]`. Select 1 is the set mask, which takes `cfg_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Cache idle and able to take a request |
| resp_valid | output | 1 | Fetch response valid for one cycle |
| resp_data | output | 32 | Fetched instruction word |
| refill_req_valid | output | 1 | Line request toward memory, held until served |
| refill_addr | output | 32 | Line-aligned address of the requested line |
| refill_valid | input | 1 | Memory returns the requested line |
| refill_data | input | 128 | Returned line, word 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects way-select, 1 selects set mask |
| cfg_wdata | input | 8 | Configuration write value |
| hit_evt | output | 1 | One-cycle pulse per hit |
| miss_evt | output | 1 | One-cycle pulse per miss |

## Verification
Take edge k as the edge at which a request is accepted. A hit on an awake line shows its response and `hit_evt` after edge k+1. A wake-up pushes the hit or miss decision to edge k+2. A miss shows `miss_evt` and the line request after the decision edge, and its response follows the edge at which `refill_valid` is sampled. The bench drives and samples on falling edges. It predicts the wake and hit outcomes, the victim way and the data from a behavioural model, and then checks the outputs on every cycle of each transaction. In the cycles before the due one it expects the response and events low, and in the cycle after it expects them low again.

// File: rtl/ricache_pkg.sv
package ricache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WAKE,
    ST_REFILL
  } ic_state_e;

  localparam logic CFG_SEL_WAYS = 1'b0;
  localparam logic CFG_SEL_MASK = 1'b1;
endpackage

// File: rtl/ricache_cfg_regs.sv
module ricache_cfg_regs
  import ricache_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int IDX_W    = 8,
  parameter int CFG_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                sel,
  input  logic [CFG_W-1:0]    wdata,
  output logic [NUM_WAYS-1:0] way_en,
  output logic [IDX_W-1:0]    set_mask
);
  localparam logic [NUM_WAYS-1:0] WAY0_ONLY = NUM_WAYS'(1);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      way_en   <= '1;
      set_mask <= '1;
    end else if (we) begin
      if (sel == CFG_SEL_MASK) begin
        set_mask <= wdata[IDX_W-1:0];
      end else if (wdata[NUM_WAYS-1:0] == '0) begin
        way_en <= WAY0_ONLY;
      end else begin
        way_en <= wdata[NUM_WAYS-1:0];
      end
    end
  end
endmodule

// File: rtl/ricache_way_ram.sv
module ricache_way_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 156
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/ricache_victim_sel.sv
module ricache_victim_sel #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic [NUM_WAYS-1:0] valid,
  input  logic [NUM_WAYS-1:0] en,
  input  logic [WAY_W-1:0]    ptr,
  output logic [WAY_W-1:0]    victim
);
  logic             found;
  logic [WAY_W-1:0] cand;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    cand   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!found && en[w] && !valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    for (int k = 0; k < NUM_WAYS; k++) begin
      cand = ptr + WAY_W'(k);
      if (!found && en[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ricache_line_state.sv
module ricache_line_state #(
  parameter int NUM_WAYS = 4,
  parameter int SETS     = 256,
  parameter int IDX_W    = 8,
  parameter int WAY_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_WAYS-1:0] way_en,
  input  logic [IDX_W-1:0]    set_mask,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                wake,
  input  logic                fill_we,
  input  logic [WAY_W-1:0]    fill_way,
  input  logic [IDX_W-1:0]    fill_idx,
  output logic [NUM_WAYS-1:0] valid_row,
  output logic [NUM_WAYS-1:0] awake_row,
  output logic [WAY_W-1:0]    ptr_row
);
  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [NUM_WAYS-1:0] awake_q [SETS];
  logic [WAY_W-1:0]    ptr_q   [SETS];

  assign valid_row = valid_q[rd_idx];
  assign awake_row = awake_q[rd_idx];
  assign ptr_row   = ptr_q[rd_idx];

  // valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else if (fill_we) begin
      valid_q[fill_idx][fill_way] <= 1'b1;
      ptr_q[fill_idx]             <= fill_way + 1'b1;
    end
  end

  // awake flags: set by a wake, cleared whenever the line leaves the region
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        awake_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          awake_q[s][w] <= (awake_q[s][w] | (wake && (rd_idx == IDX_W'(s))))
                           & way_en[w]
                           & ((IDX_W'(s) & ~set_mask) == '0);
        end
      end
    end
  end
endmodule

// File: rtl/rcfg_icache.sv
module rcfg_icache
  import ricache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_WAYS   = 4,
  parameter int SETS       = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         req_ready,
  output logic                         resp_valid,
  output logic [WORD_W-1:0]            resp_data,
  output logic                         refill_req_valid,
  output logic [ADDR_W-1:0]            refill_addr,
  input  logic                         refill_valid,
  input  logic [LINE_WORDS*WORD_W-1:0] refill_data,
  input  logic                         cfg_we,
  input  logic                         cfg_sel,
  input  logic [$clog2(SETS)-1:0]      cfg_wdata,
  output logic                         hit_evt,
  output logic                         miss_evt
);
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + WOFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int RAM_W  = TAG_W + LINE_W;
  localparam int WAY_W  = $clog2(NUM_WAYS);

  ic_state_e           state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [IDX_W-1:0]    idx_q;
  logic [WAY_W-1:0]    victim_q;
  logic [NUM_WAYS-1:0] way_en;
  logic [IDX_W-1:0]    set_mask;
  logic [NUM_WAYS-1:0] valid_row, awake_row, hit_vec;
  logic [WAY_W-1:0]    ptr_row, victim;
  logic [RAM_W-1:0]    way_rd [NUM_WAYS];
  logic [LINE_W-1:0]   hit_line;
  logic [IDX_W-1:0]    lk_idx;
  logic                accept, wake_need, do_cmp, hit_any, fill_we;

  logic unused_lsb;
  assign unused_lsb = ^addr_q[BOFF_W-1:0];

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WOFF_W-1:0] o);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < LINE_WORDS; i++) begin
      if (o == WOFF_W'(i)) r = ln[i*WORD_W +: WORD_W];
    end
    return r;
  endfunction

  ricache_cfg_regs #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .CFG_W(IDX_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .way_en(way_en), .set_mask(set_mask)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign lk_idx    = req_addr[OFF_W +: IDX_W] & set_mask;
  assign fill_we   = (state_q == ST_REFILL) && refill_valid;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    ricache_way_ram #(.DEPTH(SETS), .AW(IDX_W), .W(RAM_W)) ram_i (
      .clk(clk), .re(accept), .raddr(lk_idx), .rdata(way_rd[g]),
      .we(fill_we && (victim_q == WAY_W'(g))), .waddr(idx_q),
      .wdata({addr_q[ADDR_W-1:OFF_W], refill_data})
    );
    assign hit_vec[g] = valid_row[g] && way_en[g]
                        && (way_rd[g][RAM_W-1 -: TAG_W] == addr_q[ADDR_W-1:OFF_W]);
  end

  ricache_line_state #(.NUM_WAYS(NUM_WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)) st_i (
    .clk(clk), .rst(rst), .way_en(way_en), .set_mask(set_mask), .rd_idx(idx_q),
    .wake((state_q == ST_LOOKUP) && wake_need),
    .fill_we(fill_we), .fill_way(victim_q), .fill_idx(idx_q),
    .valid_row(valid_row), .awake_row(awake_row), .ptr_row(ptr_row)
  );

  ricache_victim_sel #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) vs_i (
    .valid(valid_row), .en(way_en), .ptr(ptr_row), .victim(victim)
  );

  always_comb begin
    hit_line = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) hit_line = hit_line | way_rd[w][LINE_W-1:0];
    end
  end

  assign hit_any   = |hit_vec;
  assign wake_need = |(way_en & ~awake_row);
  assign do_cmp    = ((state_q == ST_LOOKUP) && !wake_need) || (state_q == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      addr_q           <= '0;
      idx_q            <= '0;
      victim_q         <= '0;
      resp_valid       <= 1'b0;
      resp_data        <= '0;
      refill_req_valid <= 1'b0;
      refill_addr      <= '0;
      hit_evt          <= 1'b0;
      miss_evt         <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      hit_evt    <= 1'b0;
      miss_evt   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            idx_q   <= lk_idx;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP, ST_WAKE: begin
          if (!do_cmp) begin
            state_q <= ST_WAKE;
          end else if (hit_any) begin
            resp_valid <= 1'b1;
            resp_data  <= pick_word(hit_line, addr_q[OFF_W-1:BOFF_W]);
            hit_evt    <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            miss_evt         <= 1'b1;
            refill_req_valid <= 1'b1;
            refill_addr      <= {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            victim_q         <= victim;
            state_q          <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (refill_valid) begin
            refill_req_valid <= 1'b0;
            resp_valid       <= 1'b1;
            resp_data        <= pick_word(refill_data, addr_q[OFF_W-1:BOFF_W]);
            state_q          <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ricache_checker.sv
module ricache_checker #(
  parameter int ADDR_W   = 32,
  parameter int NUM_WAYS = 4,
  parameter int OFF_W    = 4,
  parameter int WAY_W    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_ready,
  input logic                resp_valid,
  input logic                hit_evt,
  input logic                miss_evt,
  input logic                refill_req_valid,
  input logic                refill_valid,
  input logic [ADDR_W-1:0]   refill_addr,
  input logic                fill_we,
  input logic [WAY_W-1:0]    fill_way,
  input logic [NUM_WAYS-1:0] way_en
);
  a_r2_events_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_evt, miss_evt}));

  a_r2_resp_frees_port: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

  a_r3_miss_opens_refill: assert property (@(posedge clk) disable iff (rst)
    miss_evt |-> (refill_req_valid && !resp_valid));

  a_r3_refill_held: assert property (@(posedge clk) disable iff (rst)
    (refill_req_valid && !refill_valid) |=> (refill_req_valid && $stable(refill_addr)));

  a_r3_refill_aligned: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |-> (refill_addr[OFF_W-1:0] == '0));

  a_r6_fill_in_enabled_way: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> way_en[fill_way]);

  a_r7_never_no_way: assert property (@(posedge clk) disable iff (rst)
    $countones(way_en) >= 1);
endmodule

bind rcfg_icache ricache_checker #(
  .ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS), .OFF_W(OFF_W), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_valid(resp_valid),
  .hit_evt(hit_evt), .miss_evt(miss_evt), .refill_req_valid(refill_req_valid),
  .refill_valid(refill_valid), .refill_addr(refill_addr), .fill_we(fill_we),
  .fill_way(victim_q), .way_en(way_en)
);

// File: tb/rcfg_icache_tb_top.sv
module rcfg_icache_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_ready, resp_valid, refill_req_valid, hit_evt, miss_evt;
  logic [31:0]  resp_data, refill_addr;
  logic         refill_valid = 1'b0;
  logic [127:0] refill_data = '0;
  logic         cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]   cfg_wdata = '0;

  int  n_chk = 0, n_err = 0;
  bit  done = 0;

  // behavioural model state
  bit         m_valid [4][256];
  bit         m_awake [4][256];
  logic [27:0] m_tag  [4][256];
  int         m_ptr   [256];
  logic [3:0] m_en = 4'hF;
  logic [7:0] m_mask = 8'hFF;

  always #5 clk = ~clk;

  rcfg_icache dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .refill_req_valid(refill_req_valid), .refill_addr(refill_addr),
    .refill_valid(refill_valid), .refill_data(refill_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hit_evt(hit_evt), .miss_evt(miss_evt)
  );

  function automatic logic [31:0] memword(input logic [27:0] ln, input int i);
    return ({4'h0, ln} * 32'h9E3779B1) ^ (32'(i) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic quiet(input string rq);
    chk(rq, "resp_valid idle", 32'(resp_valid), 0);
    chk(rq, "hit_evt idle", 32'(hit_evt), 0);
    chk(rq, "miss_evt idle", 32'(miss_evt), 0);
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_mask = val;
    else m_en = (val[3:0] == 4'h0) ? 4'h1 : val[3:0];
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++)
        if (!m_en[w] || ((8'(s) & ~m_mask) != 8'h0)) m_awake[w][s] = 0;
    @(negedge clk);
    quiet("R11");
  endtask

  task automatic fetch(input logic [31:0] a, input int lat, input string rq);
    logic [27:0] t;
    int idx, wo, hw, v;
    bit wk, found;
    logic [31:0] expw;
    logic [127:0] ln;
    t = a[31:4];
    idx = int'(a[11:4] & m_mask);
    wo = int'(a[3:2]);
    wk = 0;
    for (int w = 0; w < 4; w++) if (m_en[w] && !m_awake[w][idx]) wk = 1;
    if (wk) for (int w = 0; w < 4; w++) if (m_en[w]) m_awake[w][idx] = 1;
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (m_en[w] && m_valid[w][idx] && m_tag[w][idx] == t) hw = w;
    expw = memword(t, wo);

    @(negedge clk);
    chk("R1", "req_ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "req_ready busy", 32'(req_ready), 0);
    quiet(rq);
    if (wk) begin
      @(negedge clk);
      quiet("R9");
    end
    @(negedge clk);
    if (hw >= 0) begin
      chk(rq, "hit resp_valid", 32'(resp_valid), 1);
      chk(rq, "hit_evt", 32'(hit_evt), 1);
      chk(rq, "miss_evt on hit", 32'(miss_evt), 0);
      chk("R10", "hit data", resp_data, expw);
    end else begin
      chk(rq, "miss_evt", 32'(miss_evt), 1);
      chk(rq, "hit_evt on miss", 32'(hit_evt), 0);
      chk("R3", "refill_req_valid", 32'(refill_req_valid), 1);
      chk("R3", "refill_addr", refill_addr, {t, 4'h0});
      chk("R3", "no early resp", 32'(resp_valid), 0);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        chk("R3", "refill held", 32'(refill_req_valid), 1);
        quiet("R3");
      end
      for (int i = 0; i < 4; i++) ln[i*32 +: 32] = memword(t, i);
      refill_valid = 1'b1; refill_data = ln;
      @(negedge clk);
      refill_valid = 1'b0;
      chk("R3", "refill resp_valid", 32'(resp_valid), 1);
      chk("R10", "refill data", resp_data, expw);
      chk("R3", "refill dropped", 32'(refill_req_valid), 0);
      // model fill
      found = 0; v = 0;
      for (int w = 0; w < 4; w++)
        if (!found && m_en[w] && !m_valid[w][idx]) begin v = w; found = 1; end
      for (int k = 0; k < 4; k++)
        if (!found && m_en[(m_ptr[idx] + k) % 4]) begin v = (m_ptr[idx] + k) % 4; found = 1; end
      m_valid[v][idx] = 1; m_tag[v][idx] = t; m_ptr[idx] = (v + 1) % 4;
    end
    @(negedge clk);
    quiet(rq);
    chk(rq, "req_ready after resp", 32'(req_ready), 1);
  endtask

  initial begin
    for (int s = 0; s < 256; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_valid[w][s] = 0; m_awake[w][s] = 0; m_tag[w][s] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 1);
    chk("R1", "refill_req_valid", 32'(refill_req_valid), 0);
    quiet("R1");
    // R9 wake + R3 miss, then R2 hits on other words (R10)
    fetch(32'h0000_1000, 2, "R9");
    fetch(32'h0000_1004, 0, "R2");
    fetch(32'h0000_100C, 0, "R2");
    // R6: fill remaining ways, then rotate
    fetch(32'h0000_2000, 1, "R6");
    fetch(32'h0000_3008, 0, "R6");
    fetch(32'h0000_4000, 3, "R6");
    fetch(32'h0000_5000, 1, "R6");
    fetch(32'h0000_1000, 1, "R6");
    // R5: restrict to ways 0,1
    cfg_write(1'b0, 8'h03);
    fetch(32'h0000_3000, 1, "R5");
    // R8: re-enable all, earlier lines still present
    cfg_write(1'b0, 8'h0F);
    fetch(32'h0000_4004, 0, "R8");
    fetch(32'h0000_2000, 0, "R8");
    // R7: zero way select
    cfg_write(1'b0, 8'h00);
    fetch(32'h0000_2004, 2, "R7");
    fetch(32'h0000_4000, 1, "R7");
    cfg_write(1'b0, 8'h0F);
    // R4: set mask aliasing
    cfg_write(1'b1, 8'h1F);
    fetch(32'h0000_1200, 1, "R4");
    fetch(32'h0000_0050, 0, "R4");
    fetch(32'h0000_0250, 2, "R4");
    fetch(32'h0000_0054, 0, "R4");
    cfg_write(1'b1, 8'hFF);
    fetch(32'h0000_1204, 1, "R4");
    cfg_write(1'b1, 8'h1F);
    cfg_write(1'b1, 8'hFF);
    fetch(32'h0000_1208, 0, "R9");
    // mixed traffic under changing regions
    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0) begin
        cfg_write(1'b0, 8'($urandom % 16));
        case ($urandom % 4)
          0: cfg_write(1'b1, 8'hFF);
          1: cfg_write(1'b1, 8'h1F);
          2: cfg_write(1'b1, 8'h03);
          default: cfg_write(1'b1, 8'h00);
        endcase
      end
      fetch({20'h0, 4'($urandom % 6), 2'b00, 2'($urandom % 3), 2'($urandom % 4), 2'b00},
            int'($urandom % 4), "R6");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule